// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous SRAM with registered inputs and a registered read path. It is meant to sit as a secondary data store behind either a processor or a cache controller. Each of these has its own active-low address strobe. A strobe that arrives while all three chip selects are active starts an access. A strobe that arrives while any chip select is inactive deselects the part. After an access has started, cycles without a strobe continue it. The access then either holds its address or steps a two-bit wrapping burst counter, depending on the advance input.

Every control input is sampled on the rising clock edge. A read captured at one edge places its word in the output register at the next edge. A write captured at one edge commits its data to the array at the next edge. Writes use byte lanes. A global write enable forces all lanes on. Otherwise a byte-write enable and one select per lane choose the lanes to write. The data bus is split into a data-out vector, a data-in vector and a drive-enable. An asynchronous output enable gates the drive-enable.

Top module: `sbsram_core`

## Requirements
- R1: An access starts when a strobe is low at a rising edge with all chip selects active (`cs0_n` low, `cs1` high, `cs2_n` low). With `gwe_n` and `bwe_n` both high, the access is a read. If the read is captured at edge k, the addressed word appears on `rdata_o` after edge k+1, with `rdrv_o` high when `oe_n` is low.
- R2: Reads that start on consecutive edges each return their own word on consecutive cycles, with no idle cycle between them.
- R3: The processor strobe `strb_proc_n` is ignored while `cs0_n` is high. With `strb_ctrl_n` high, the cycle continues the current access at its current address.
- R4: The processor strobe starts reads and writes exactly as the controller strobe does when all chip selects are active.
- R5: A strobe that is low while any chip select is inactive deselects the part. `rdrv_o` is low from that same edge on, even if a read was captured at the edge before.
- R6: In the cycle after the edge that captures the first access after a deselected state, and also after reset, `rdrv_o` is low whatever the level of `oe_n`.
- R7: `oe_n` acts asynchronously. While `oe_n` is high, `rdrv_o` is low. When `oe_n` falls, valid read data is driven within the same cycle.
- R8: When `gwe_n` is low, a write updates all byte lanes, whatever the values of `bwe_n` and `bsel_n`.
- R9: When `gwe_n` is high and `bwe_n` is low, lane i (bits 8i+7..8i) is written only if `bsel_n[i]` is low. The other lanes keep their contents.
- R10: A write captured at edge k is visible to a read of the same address captured at edge k+1.
- R11: On a cycle with no strobe and `adv_n` low, the two low address bits advance. With `burst_ilv` low, offset n gives bits (base+n) mod 4. With `burst_ilv` high, offset n gives bits base XOR n. The upper address bits stay at the captured value.
- R12: On a cycle with no strobe and `adv_n` high, the address is held. While the part is selected, every cycle without a strobe is a read or a write, as `gwe_n` and `bwe_n` decide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, captured when an access starts |
| strb_proc_n | input | 1 | Processor address strobe, active low, qualified by cs0_n |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1 | input | 1 | Chip select 1, active high |
| cs2_n | input | 1 | Chip select 2, active low |
| gwe_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NB | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| wdata_i | input | NB*8 | Write data |
| rdata_o | output | NB*8 | Registered read data |
| rdrv_o | output | 1 | Output drive enable for rdata_o |

## Verification
The hardest case to reach is a deselect that lands one edge after a read is captured. The read data is then already on its way into the output register, and the drive-enable has to stay off anyway. The bench puts a deselecting strobe right behind a read. It also mixes strobes, chip-select patterns and continuation cycles at random, so that deselects, processor strobes blocked by `cs0_n`, and bursts that wrap both ways all fall next to pending reads. A reference model in the bench, with the same two-cycle view of the pipeline, predicts every output.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic start;   // strobe with every select active
        logic desel;   // strobe with some select inactive
        logic step;    // continuation cycle that advances the burst
        op_e  op;      // operation captured at this edge
    } dec_s;

    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] idx,
                                                input logic       ilv);
        return ilv ? (base ^ idx) : (base + idx);
    endfunction

endpackage

// File: rtl/sbsram_cmd_dec.sv
module sbsram_cmd_dec
    import sbsram_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          strb_proc_n,
    input  logic          strb_ctrl_n,
    input  logic          adv_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          gwe_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          sel_q,
    output dec_s          dec_o,
    output logic [NB-1:0] mask_o
);

    logic all_cs;
    logic proc_ok;
    logic ctrl_ok;
    logic any_strb;
    logic wr_req;

    assign all_cs   = !cs0_n && cs1 && !cs2_n;
    assign proc_ok  = !strb_proc_n && !cs0_n;
    assign ctrl_ok  = !strb_ctrl_n;
    assign any_strb = proc_ok || ctrl_ok;
    assign wr_req   = !gwe_n || !bwe_n;

    always_comb begin
        dec_o.start = any_strb && all_cs;
        dec_o.desel = any_strb && !all_cs;
        dec_o.step  = !any_strb && sel_q && !adv_n;
        if (dec_o.start || (!any_strb && sel_q))
            dec_o.op = wr_req ? OP_WRITE : OP_READ;
        else
            dec_o.op = OP_IDLE;
    end

    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign mask_o[l] = !gwe_n || (!bwe_n && !bsel_n[l]);
    end

endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
    import sbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          step_i,
    input  logic          ilv_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] eff_addr_o
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (start_i) begin
            base_q <= addr_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    assign eff_addr_o = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_q, ilv_i)};

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] mask_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          kill_i,
    output logic [DW-1:0] dout_o,
    output logic          valid_o
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (op_i == OP_WRITE) begin
            for (int l = 0; l < NB; l++) begin
                if (mask_i[l])
                    mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= (op_i == OP_READ) && !kill_i;
            if (op_i == OP_READ)
                dout_o <= mem_q[addr_i];
        end
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          strb_proc_n,
    input  logic          strb_ctrl_n,
    input  logic          adv_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          gwe_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          oe_n,
    input  logic          burst_ilv,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rdrv_o
);

    dec_s          dec_w;
    logic [NB-1:0] mask_w;
    logic          dec_start;
    logic          dec_desel;
    logic          sel_q;
    op_e           op_q;
    logic [NB-1:0] mask_q;
    logic [DW-1:0] wdata_q;
    logic [AW-1:0] eff_addr;
    logic          drv_q;

    sbsram_cmd_dec #(.NB(NB)) dec_i (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .cs0_n       (cs0_n),
        .cs1         (cs1),
        .cs2_n       (cs2_n),
        .gwe_n       (gwe_n),
        .bwe_n       (bwe_n),
        .bsel_n      (bsel_n),
        .sel_q       (sel_q),
        .dec_o       (dec_w),
        .mask_o      (mask_w)
    );

    assign dec_start = dec_w.start;
    assign dec_desel = dec_w.desel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            op_q    <= OP_IDLE;
            mask_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (dec_w.start)
                sel_q <= 1'b1;
            else if (dec_w.desel)
                sel_q <= 1'b0;
            op_q    <= dec_w.op;
            mask_q  <= mask_w;
            wdata_q <= wdata_i;
        end
    end

    sbsram_burst_ctr #(.AW(AW)) ctr_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (dec_w.start),
        .step_i     (dec_w.step),
        .ilv_i      (burst_ilv),
        .addr_i     (addr_i),
        .eff_addr_o (eff_addr)
    );

    sbsram_array #(.DEPTH(DEPTH), .NB(NB)) arr_i (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op_q),
        .addr_i  (eff_addr),
        .mask_i  (mask_q),
        .wdata_i (wdata_q),
        .kill_i  (dec_w.desel),
        .dout_o  (rdata_o),
        .valid_o (drv_q)
    );

    assign rdrv_o = drv_q && !oe_n;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
    import sbsram_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rdrv_o,
    input logic          drv_q,
    input logic          dec_start,
    input logic          dec_desel,
    input logic          sel_q,
    input op_e           op_q,
    input logic [NB-1:0] mask_q,
    input logic          gwe_n,
    input logic          strb_proc_n,
    input logic          strb_ctrl_n,
    input logic          cs0_n,
    input logic          adv_n,
    input logic [AW-1:0] eff_addr
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        dec_desel |=> !rdrv_o);                                             // R5

    AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel_q |=> !rdrv_o);                                                // R6

    AST_READ_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_READ && !dec_desel) |=> drv_q);                         // R1

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (dec_start && !gwe_n) |=> (op_q == OP_WRITE && mask_q == '1));      // R8

    AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!strb_proc_n && cs0_n && strb_ctrl_n && adv_n) |=> $stable(eff_addr)); // R3

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (strb_proc_n && strb_ctrl_n && adv_n) |=> $stable(eff_addr));      // R12

endmodule

bind sbsram_core sbsram_chk #(.NB(NB), .AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rdrv_o      (rdrv_o),
    .drv_q       (drv_q),
    .dec_start   (dec_start),
    .dec_desel   (dec_desel),
    .sel_q       (sel_q),
    .op_q        (op_q),
    .mask_q      (mask_q),
    .gwe_n       (gwe_n),
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .cs0_n       (cs0_n),
    .adv_n       (adv_n),
    .eff_addr    (eff_addr)
);

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;

    localparam int DEPTH = 256;
    localparam int NB    = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int DW    = NB * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          strb_proc_n, strb_ctrl_n, adv_n;
    logic          cs0_n, cs1, cs2_n;
    logic          gwe_n, bwe_n;
    logic [NB-1:0] bsel_n;
    logic          oe_n, burst_ilv;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          rdrv_o;

    always #4 clk = ~clk;

    sbsram_core #(.DEPTH(DEPTH), .NB(NB)) dut_i (
        .clk (clk), .rst (rst), .addr_i (addr_i),
        .strb_proc_n (strb_proc_n), .strb_ctrl_n (strb_ctrl_n), .adv_n (adv_n),
        .cs0_n (cs0_n), .cs1 (cs1), .cs2_n (cs2_n),
        .gwe_n (gwe_n), .bwe_n (bwe_n), .bsel_n (bsel_n),
        .oe_n (oe_n), .burst_ilv (burst_ilv), .wdata_i (wdata_i),
        .rdata_o (rdata_o), .rdrv_o (rdrv_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    bit [DW-1:0] mm [DEPTH];
    bit          m_sel = 1'b0;
    int          m_base = 0;
    int          m_cnt = 0;
    bit          s1v = 1'b0, s2v = 1'b0;
    bit [DW-1:0] s1d = '0, s2d = '0;
    string       s1t = "", s2t = "";
    bit          last_v = 1'b0;
    bit [DW-1:0] last_d = '0;

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int burst_addr(input int base, input int cnt, input bit ilv);
        int lo;
        lo = ilv ? ((base & 3) ^ cnt) : (((base & 3) + cnt) & 3);
        return (base & ~3) | lo;
    endfunction

    task automatic check_out;
        bit ev;
        ev = s2v && !oe_n;
        chk1({s2t, " drive"}, {{(DW-1){1'b0}}, rdrv_o}, {{(DW-1){1'b0}}, ev});
        if (ev && rdrv_o)
            chk1({s2t, " data"}, rdata_o, s2d);
        last_v = s2v;
        last_d = s2d;
    endtask

    task automatic issue(input bit pn, input bit cn, input bit advn,
                         input bit c0n, input bit c1, input bit c2n,
                         input bit gwn, input bit bwn, input bit [NB-1:0] bsn,
                         input bit oen, input int a, input bit [DW-1:0] d,
                         input string tag);
        bit allcs, pok, cok, st, ds, act, wr;
        int ea;
        @(negedge clk);
        check_out();
        strb_proc_n = pn; strb_ctrl_n = cn; adv_n = advn;
        cs0_n = c0n; cs1 = c1; cs2_n = c2n;
        gwe_n = gwn; bwe_n = bwn; bsel_n = bsn;
        oe_n = oen; addr_i = a[AW-1:0]; wdata_i = d;
        allcs = !c0n && c1 && !c2n;
        pok   = !pn && !c0n;
        cok   = !cn;
        st    = (pok || cok) && allcs;
        ds    = (pok || cok) && !allcs;
        wr    = !gwn || !bwn;
        act   = st || (!(pok || cok) && m_sel);
        if (st) begin
            m_base = a; m_cnt = 0; m_sel = 1'b1;
        end else if (ds) begin
            m_sel = 1'b0;
        end else if (m_sel && !advn) begin
            m_cnt = (m_cnt + 1) & 3;
        end
        ea  = burst_addr(m_base, m_cnt, burst_ilv);
        s2v = s1v && !ds; s2d = s1d; s2t = s1t;
        s1v = act && !wr; s1d = mm[ea]; s1t = tag;
        if (act && wr)
            for (int l = 0; l < NB; l++)
                if (!gwn || !bsn[l]) mm[ea][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic rd(input int a, input string tag);
        issue(1, 0, 1, 0, 1, 0, 1, 1, '1, 0, a, '0, tag);
    endtask
    task automatic rd_p(input int a, input string tag);
        issue(0, 1, 1, 0, 1, 0, 1, 1, '1, 0, a, '0, tag);
    endtask
    task automatic wr_g(input int a, input bit [DW-1:0] d, input string tag);
        issue(1, 0, 1, 0, 1, 0, 0, 1, '1, 0, a, d, tag);
    endtask
    task automatic wr_b(input int a, input bit [DW-1:0] d, input bit [NB-1:0] bsn, input string tag);
        issue(1, 0, 1, 0, 1, 0, 1, 0, bsn, 0, a, d, tag);
    endtask
    task automatic cont(input bit advn, input string tag);
        issue(1, 1, advn, 0, 1, 0, 1, 1, '1, 0, 0, '0, tag);
    endtask
    task automatic desel(input string tag);
        issue(1, 0, 1, 0, 0, 0, 1, 1, '1, 0, 0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin : stim
        int r;
        r = $urandom(32'h5eed1);
        rst = 1'b1;
        strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
        cs0_n = 1; cs1 = 0; cs2_n = 1; gwe_n = 1; bwe_n = 1; bsel_n = '1;
        oe_n = 0; burst_ilv = 0; addr_i = '0; wdata_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk1("R6 reset drive", {{(DW-1){1'b0}}, rdrv_o}, '0);

        // fill the low words
        for (int i = 0; i < 16; i++) wr_g(i, $urandom, "R8 fill");

        // R1 and R2: back-to-back reads
        rd(3, "R1 single");
        rd(4, "R2 b2b"); rd(5, "R2 b2b"); rd(6, "R2 b2b"); rd(7, "R2 b2b");

        // R4: processor strobe write then read
        issue(0, 1, 1, 0, 1, 0, 0, 1, '1, 0, 12, 32'hCAFE_F00D, "R4 write");
        rd_p(12, "R4 proc read");

        // R8 and R9: lane control
        wr_g(5, 32'h1122_3344, "R8 gw");
        wr_b(5, 32'hAABB_CCDD, 4'b1010, "R9 lanes");
        rd(5, "R9 merged");
        wr_b(5, 32'h5566_7788, 4'b1111, "R9 none");
        rd(5, "R9 none kept");
        issue(1, 0, 1, 0, 1, 0, 0, 0, 4'b1111, 0, 6, 32'h0BAD_BEEF, "R8 override");
        rd(6, "R8 all lanes");

        // R10: write then read next cycle
        wr_g(9, 32'h1357_9BDF, "R10 write");
        rd(9, "R10 fresh read");

        // R12: hold with adv_n high
        cont(1, "R12 hold"); cont(1, "R12 hold");

        // R7: asynchronous output enable
        cont(1, "R7 setup");
        if (last_v) begin
            #1 oe_n = 1'b1;
            #1 chk1("R7 oe high", {{(DW-1){1'b0}}, rdrv_o}, '0);
            oe_n = 1'b0;
            #1 chk1("R7 oe low", {{(DW-1){1'b0}}, rdrv_o}, {{(DW-1){1'b0}}, 1'b1});
        end else begin
            chk1("R7 setup valid", '0, {{(DW-1){1'b0}}, 1'b1});
        end

        // R3: blocked processor strobe keeps the burst address
        rd(10, "R3 base");
        issue(0, 1, 1, 1, 1, 0, 1, 1, '1, 0, 2, '0, "R3 ignored");
        cont(1, "R3 after");

        // R5: deselect right behind a read
        rd(11, "R5 killed");
        desel("R6 deselected");
        rd(13, "R6 first");
        rd(14, "R5 reselected");
        issue(0, 1, 1, 0, 0, 0, 1, 1, '1, 0, 0, '0, "R5 proc desel");
        cont(0, "R5 stays off");

        // R11: bursts in both orders
        rd(9, "R11 linear"); cont(0, "R11 linear"); cont(0, "R11 linear"); cont(0, "R11 wrap");
        desel("R6 gap");
        burst_ilv = 1'b1;
        rd(9, "R11 ilv"); cont(0, "R11 ilv"); cont(0, "R11 ilv"); cont(0, "R11 ilv");
        issue(1, 1, 0, 0, 1, 0, 0, 1, '1, 0, 0, 32'h2468_ACE0, "R11 burst write");
        rd(9, "R11 ilv check"); cont(0, "R11 ilv check");
        desel("R6 gap");
        burst_ilv = 1'b0;

        // random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            bit gwn, bwn;
            bit [NB-1:0] bsn;
            bit oen;
            k   = $urandom_range(0, 9);
            gwn = ($urandom_range(0, 9) >= 2);
            bwn = ($urandom_range(0, 9) >= 3);
            if ($urandom_range(0, 9) < 6) begin gwn = 1; bwn = 1; end
            bsn = NB'($urandom);
            oen = ($urandom_range(0, 9) == 0);
            if (i == 300) begin
                desel("R6 gap");
                burst_ilv = 1'b1;
            end
            case (k)
                0, 1, 2, 3: issue(1, 0, 1, 0, 1, 0, gwn, bwn, bsn, oen,
                                  $urandom_range(0, 15), $urandom, "R1 rnd ctrl");
                4, 5:       issue(0, 1, 1, $urandom_range(0, 3) == 0, 1, 0, gwn, bwn, bsn, oen,
                                  $urandom_range(0, 15), $urandom, "R3 rnd proc");
                6:          issue($urandom_range(0, 1), 0, 1, $urandom_range(0, 1),
                                  $urandom_range(0, 1), 1, 1, 1, '1, oen, 0, '0, "R5 rnd desel");
                default:    issue(1, 1, $urandom_range(0, 1), 0, 1, 0, gwn, bwn, bsn, oen,
                                  0, $urandom, "R11 rnd cont");
            endcase
        end
        cont(1, "R12 drain"); cont(1, "R12 drain"); cont(1, "R12 drain");
        done = 1'b1;
        report();
        $finish;
    end

endmodule